// File: doc/BRIEF.md
# Reversible-Cell Carry-Skip Adder

This block adds two unsigned operands and a carry-in. It returns a result one bit wider than the operands, and the top bit of that result is the carry-out. Every full-adder position is built from one four-in, four-out reversible cell. The cell takes the two operand bits, a constant-zero input and the incoming carry. It returns a pass-through of the first operand bit, the exclusive-or of the two operand bits, the sum bit and the carry bit. The exclusive-or output also serves as the bit's propagate signal, so no separate propagate logic is needed.

The bits form fixed-width skip groups. Inside a group the carry ripples from cell to cell. When every bit in the group propagates, the group's carry-out is taken straight from its carry-in through a 2:1 selector, and the ripple path is bypassed. Otherwise the carry-out comes from the last cell of the group. The adder logic itself is combinational. The result is captured in a register on the rising clock edge, so it is ready one cycle after the operands are presented. A synchronous active-high reset clears the result register.

Top module: `skip_adder_top`

## Requirements
- R1: On a rising edge with `rst` high, `result` becomes all zeros, whatever the operand inputs are.
- R2: With `rst` low, the value of `result` after each rising edge equals `op_a + op_b + carry_in` as sampled at that edge, zero-extended to WIDTH+1 bits. Bit WIDTH is the carry-out.
- R3: The reversible cell maps its 4-bit input {A,B,C,D} (A in bit 3, D in bit 0) to its 4-bit output {P,Q,R,S} (P in bit 3, S in bit 0). The outputs are P=A, Q=A^B, R=A^B^D and S=((A^B)&D)^(A&B)^C.
- R4: Cell input 4'b1000 gives cell output 4'b1110.
- R5: Over all 16 input codes, the cell's 16 outputs are pairwise distinct, so the mapping is a permutation.
- R6: With C=0, the cell's R output is the sum bit and its S output is the carry bit of A+B+D.
- R7: When `op_a ^ op_b` is all ones, `result` equals `carry_in` in bit WIDTH and `~carry_in` in every lower bit.
- R8: For `op_a`=8'b00011001, `op_b`=8'b11101010 and `carry_in`=0, `result` is 9'b100000011.
- R9: A carry that enters a group whose bits all propagate leaves that group unchanged and reaches the next group. For example, 8'h0F + 8'h00 + 1 gives 9'h010, and 8'hFF + 8'h00 + 1 gives 9'h100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| result | output | WIDTH+1 | Registered sum; bit WIDTH is the carry-out |

## Verification
All 2^17 combinations of the two 8-bit operands and the carry-in are applied back to back. This covers every mix of skipping and rippling groups, so a fault in the skip selector, the ripple chain or the group boundary shows up as a wrong sum. Directed vectors then separate three cases: both groups bypassed, only one group bypassed, and the fixed sample sum. The reversible cell is also swept on its own over its 16 input codes. That sweep checks the stated mapping, the permutation property and the full-adder reading with the constant input at zero.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } rev_in_t;

  typedef struct packed {
    logic p;
    logic q;
    logic r;
    logic s;
  } rev_out_t;
endpackage

// File: rtl/rev4_cell.sv
module rev4_cell
  import rcs_pkg::*;
(
  input  logic [3:0] vin,
  output logic [3:0] vout
);
  rev_in_t  iv;
  rev_out_t ov;
  logic     x_ab;

  assign iv   = rev_in_t'(vin);
  assign x_ab = iv.a ^ iv.b;

  always_comb begin
    ov.p = iv.a;
    ov.q = x_ab;
    ov.r = x_ab ^ iv.d;
    ov.s = (x_ab & iv.d) ^ (iv.a & iv.b) ^ iv.c;
  end

  assign vout = ov;
endmodule

// File: rtl/skip_group.sv
module skip_group
  import rcs_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic [GW-1:0] pass_a,
  output logic          cout
);
  logic [GW:0]   rip;
  logic [GW-1:0] prop;
  logic          all_prop;

  assign rip[0] = cin;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    rev_in_t  ci;
    rev_out_t co;
    logic [3:0] co_v;

    always_comb begin
      ci.a = a[i];
      ci.b = b[i];
      ci.c = 1'b0;
      ci.d = rip[i];
    end

    rev4_cell u_cell (
      .vin  (ci),
      .vout (co_v)
    );

    assign co       = rev_out_t'(co_v);
    assign sum[i]   = co.r;
    assign prop[i]  = co.q;
    assign pass_a[i] = co.p;
    assign rip[i+1] = co.s;
  end

  assign all_prop = &prop;
  assign cout     = all_prop ? cin : rip[GW];
endmodule

// File: rtl/skip_adder_top.sv
module skip_adder_top #(
  parameter int WIDTH = 8,
  parameter int GROUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH:0]   result
);
  localparam int NGRP = WIDTH / GROUP;

  logic [NGRP:0]    gcar;
  logic [WIDTH-1:0] sum_c;
  logic [WIDTH-1:0] garbage;

  assign gcar[0] = carry_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    skip_group #(.GW(GROUP)) u_grp (
      .a      (op_a[g*GROUP +: GROUP]),
      .b      (op_b[g*GROUP +: GROUP]),
      .cin    (gcar[g]),
      .sum    (sum_c[g*GROUP +: GROUP]),
      .pass_a (garbage[g*GROUP +: GROUP]),
      .cout   (gcar[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= {gcar[NGRP], sum_c};
  end
endmodule

// File: rtl/skip_adder_chk.sv
module skip_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH:0]   result,
  input logic [WIDTH-1:0] garbage
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> result == '0);

  assert_sum_matches_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> result == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {{WIDTH{1'b0}}, $past(carry_in)}));

  assert_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
    garbage == op_a);

  assert_full_skip_R7: assert property (@(posedge clk) disable iff (rst)
    ((op_a ^ op_b) == {WIDTH{1'b1}}) |=> result == {$past(carry_in), {WIDTH{~$past(carry_in)}}});

  assert_zero_ops_R2: assert property (@(posedge clk) disable iff (rst)
    (op_a == '0 && op_b == '0) |=> result == {{WIDTH{1'b0}}, $past(carry_in)});
endmodule

bind skip_adder_top skip_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .result   (result),
  .garbage  (garbage)
);

// File: tb/skip_adder_top_bench.sv
module skip_adder_top_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W:0]   result;
  logic [3:0]   cell_in = '0;
  logic [3:0]   cell_out;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  skip_adder_top #(.WIDTH(W), .GROUP(4)) u_skip_adder_top (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .result   (result)
  );

  rev4_cell u_cell_probe (
    .vin  (cell_in),
    .vout (cell_out)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string req, input logic [W:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    check(req, result, exp);
  endtask

  initial begin
    logic [15:0] seen;
    logic [W:0]  prev_exp;
    bit          have_prev;

    // Reset state: operands non-zero while reset is high (R1)
    op_a = 8'hAA; op_b = 8'h77; carry_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", result, '0);
    rst = 1'b0;

    // Cell sweep: R3, R4, R5, R6
    seen = '0;
    for (int k = 0; k < 16; k++) begin
      logic ea, eb, ec, ed;
      logic [3:0] exp_o;
      cell_in = k[3:0];
      #1;
      {ea, eb, ec, ed} = k[3:0];
      exp_o = {ea, ea ^ eb, ea ^ eb ^ ed, ((ea ^ eb) & ed) ^ (ea & eb) ^ ec};
      check("R3", {5'b0, cell_out}, {5'b0, exp_o});
      if (seen[cell_out] === 1'b1) check("R5", {5'b0, cell_out}, 9'h1FF);
      seen[cell_out] = 1'b1;
      if (ec == 1'b0) begin
        logic [1:0] ar;
        ar = {1'b0, ea} + {1'b0, eb} + {1'b0, ed};
        check("R6", {7'b0, cell_out[0], cell_out[1]}, {7'b0, ar});
      end
      if (k == 8) check("R4", {5'b0, cell_out}, 9'b0_0000_1110);
    end
    check("R5", {1'b0, seen[7:0]}, {1'b0, 8'hFF});
    check("R5", {1'b0, seen[15:8]}, {1'b0, 8'hFF});

    // Directed vectors
    apply(8'b00011001, 8'b11101010, 1'b0, "R8", 9'b100000011);
    apply(8'h0F, 8'hF0, 1'b1, "R7", 9'h100);
    apply(8'h5A, 8'hA5, 1'b0, "R7", 9'h0FF);
    apply(8'h0F, 8'h00, 1'b1, "R9", 9'h010);
    apply(8'hFF, 8'h00, 1'b1, "R9", 9'h100);
    apply(8'hF0, 8'h00, 1'b1, "R9", 9'h0F1);

    // Reset mid-run clears result (R1)
    @(negedge clk); rst = 1'b1; op_a = 8'hFF; op_b = 8'hFF;
    @(negedge clk); check("R1", result, '0);
    rst = 1'b0;

    // Exhaustive sweep, pipelined one vector per cycle (R2)
    have_prev = 0;
    prev_exp  = '0;
    for (int v = 0; v < (1 << (2*W+1)); v++) begin
      logic [W-1:0] va, vb;
      logic vc;
      @(negedge clk);
      if (have_prev) check("R2", result, prev_exp);
      {vc, vb, va} = v[2*W:0];
      op_a = va; op_b = vb; carry_in = vc;
      prev_exp  = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
      have_prev = 1;
    end
    @(negedge clk);
    check("R2", result, prev_exp);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule